// File: doc/BRIEF.md
# Microcontroller Power Mode and Reset Controller

This block holds the operating state of a small 8-bit microcontroller core. It runs from the oscillator clock. It decides when the CPU clock, the peripheral clock and the oscillator itself are enabled. It drives the internal reset to the special function registers and a write inhibit for internal RAM. It accepts an asynchronous reset pin and two one-cycle request strobes, one for idle and one for power-down, which come from a control register write. It also takes an interrupt-pending flag from the interrupt controller.

A stray pulse on the reset pin is filtered out. The pin is first synchronised. The synchronised level must then stay high for a whole number of machine cycles before the internal reset acts. Idle stops only the CPU clock, and an interrupt or a reset ends it. Power-down stops the oscillator, and only the reset pin ends it. The pin first restarts the oscillator. The internal reset is then held until a start-up count has expired and the pin has been released.

The FSM states are:
- RUN: everything is clocked.
- IDLE: the CPU is stopped and the peripherals run.
- IDLE_EXIT: the reset pin was seen during idle and qualification is in progress. The CPU runs again, but RAM writes are blocked.
- PDOWN: the oscillator is off.
- WAKE: the oscillator is restarting and reset is held.
- RESET: the internal reset is active.

The transitions are:
- RUN to RESET on a qualified reset.
- RUN to PDOWN on a power-down request. This also applies when both requests arrive in the same cycle.
- RUN to IDLE on an idle request.
- IDLE to IDLE_EXIT when the synchronised pin goes high.
- IDLE to RUN on a pending interrupt.
- IDLE_EXIT to RESET on a qualified reset.
- IDLE_EXIT to RUN when the pin drops before it is qualified.
- PDOWN to WAKE when the synchronised pin goes high.
- WAKE to RESET when the start-up count is done.
- RESET to RUN when the synchronised pin is low.

Power-on, through `por_n`, starts the block in WAKE.

Top module: `pmrc_ctrl`

## Requirements
- R1: While `por_n` is low, `sfr_rst` and `ram_wr_inh` are 1, `osc_en` is 1, and `cpu_clk_en` and `per_clk_en` are 0. After `por_n` rises, `cpu_clk_en` first reads 1 in the sample after clock edge OSC_START_CNT+2, provided `rst_pin` stays low.
- R2: An `idle_req` in RUN, with no `pd_req`, gives `cpu_clk_en`=0, `per_clk_en`=1 and `osc_en`=1 after the next edge. A further `idle_req` while idle changes nothing.
- R3: `irq_pend` during idle re-enables `cpu_clk_en` after the next edge.
- R4: A `pd_req` in RUN drives `osc_en`, `per_clk_en` and `cpu_clk_en` to 0 after the next edge. In power-down, `irq_pend` and `idle_req` are ignored.
- R5: When `idle_req` and `pd_req` arrive in the same cycle, power-down is entered.
- R6: In run, `sfr_rst` asserts only if `rst_pin` is high for at least RST_QUAL_MC*OSC_PER_MC consecutive clocks (24 by default). When it does, `sfr_rst` asserts SYNC_STAGES+1+RST_QUAL_MC*OSC_PER_MC edges after the pin rises. Shorter pulses have no effect.
- R7: A reset pin rising during idle restarts `cpu_clk_en` with `ram_wr_inh`=1 after edge SYNC_STAGES+1. This window lasts RST_QUAL_MC*OSC_PER_MC clocks, after which `sfr_rst` asserts. If the pin drops before it is qualified, the block returns to run with `ram_wr_inh`=0 and no `sfr_rst`.
- R8: A reset pin rising in power-down raises `osc_en` after edge SYNC_STAGES+1. From then on, `sfr_rst` stays 1 and `cpu_clk_en` stays 0 at least until the start-up count expires.
- R9: `sfr_rst` stays 1 while the synchronised pin is high, and `ram_wr_inh` is 1 whenever `sfr_rst` is 1. After the pin is released, `cpu_clk_en` returns SYNC_STAGES+1 edges later.
- R10: `cpu_clk_en`=1 implies `per_clk_en`=1, and `per_clk_en`=1 implies `osc_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_pin | input | 1 | External reset pin, asynchronous, active high |
| idle_req | input | 1 | One-cycle strobe requesting idle |
| pd_req | input | 1 | One-cycle strobe requesting power-down |
| irq_pend | input | 1 | An enabled interrupt is pending |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| sfr_rst | output | 1 | Internal reset to special function registers |
| ram_wr_inh | output | 1 | Internal RAM write inhibit |

## Verification
The reset pin is swept through pulse widths of 1 to 30 clocks while the core runs. This separates pulses just short of two machine cycles, which must be ignored, from pulses of exactly two machine cycles or longer, which must reset. A long pulse measures the qualification latency. The pin is then raised in idle, both long and short, to tell a real reset with its inhibited-RAM window from a glitch that merely wakes the CPU. It is also raised in power-down to check the oscillator restart and the hold-off. Request strobes are applied alone, together, and in states where they must be ignored. This separates the priority of power-down from the idle path and from the interrupt exit.

// File: rtl/pmrc_pkg.sv
package pmrc_pkg;

    typedef enum logic [2:0] {
        PM_RUN       = 3'd0,
        PM_IDLE      = 3'd1,
        PM_IDLE_EXIT = 3'd2,
        PM_PDOWN     = 3'd3,
        PM_WAKE      = 3'd4,
        PM_RESET     = 3'd5
    } pm_state_e;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
        logic rst;
        logic inh;
    } pm_out_t;

endpackage

// File: rtl/pmrc_sync.sv
module pmrc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain <= '0;
                else         chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge arst_n) begin
                if (!arst_n) chain <= '0;
                else         chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/pmrc_rst_qual.sv
module pmrc_rst_qual #(
    parameter int OSC_PER_MC  = 12,
    parameter int RST_QUAL_MC = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic en,
    input  logic rst_sync,
    output logic rst_ok
);

    localparam int PHW = (OSC_PER_MC > 1) ? $clog2(OSC_PER_MC) : 1;
    localparam int MCW = $clog2(RST_QUAL_MC + 1);
    localparam logic [PHW-1:0] PH_LAST = PHW'(OSC_PER_MC - 1);
    localparam logic [MCW-1:0] MC_LIM  = MCW'(RST_QUAL_MC);

    logic [PHW-1:0] phase;
    logic [MCW-1:0] mc_cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            phase  <= '0;
            mc_cnt <= '0;
        end else if (!(en && rst_sync)) begin
            phase  <= '0;
            mc_cnt <= '0;
        end else if (mc_cnt != MC_LIM) begin
            if (phase == PH_LAST) begin
                phase  <= '0;
                mc_cnt <= mc_cnt + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    assign rst_ok = (mc_cnt == MC_LIM);

    assert_qual_needs_pin_R6: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(rst_ok) |-> $past(rst_sync) && $past(en));

    assert_qual_drops_R6: assert property (@(posedge clk) disable iff (!arst_n)
        !rst_sync |=> !rst_ok);

endmodule

// File: rtl/pmrc_osc_start.sv
module pmrc_osc_start #(
    parameter int OSC_START_CNT = 1024
) (
    input  logic clk,
    input  logic arst_n,
    input  logic en,
    output logic done
);

    localparam int CW = $clog2(OSC_START_CNT + 1);
    localparam logic [CW-1:0] LIM = CW'(OSC_START_CNT);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)          cnt <= '0;
        else if (!en)         cnt <= '0;
        else if (cnt != LIM)  cnt <= cnt + 1'b1;
    end

    assign done = (cnt == LIM);

    assert_start_from_zero_R8: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(en) |-> !done);

endmodule

// File: rtl/pmrc_ctrl.sv
module pmrc_ctrl #(
    parameter int OSC_PER_MC    = 12,
    parameter int RST_QUAL_MC   = 2,
    parameter int OSC_START_CNT = 1024,
    parameter int SYNC_STAGES   = 2
) (
    input  logic clk_osc,
    input  logic por_n,
    input  logic rst_pin,
    input  logic idle_req,
    input  logic pd_req,
    input  logic irq_pend,
    output logic cpu_clk_en,
    output logic per_clk_en,
    output logic osc_en,
    output logic sfr_rst,
    output logic ram_wr_inh
);

    import pmrc_pkg::*;

    pm_state_e state, state_nx;
    pm_out_t   outs;
    logic      rst_sync;
    logic      rst_ok;
    logic      start_done;
    logic      qual_en;
    logic      wake_en;

    pmrc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk_osc),
        .arst_n (por_n),
        .d      (rst_pin),
        .q      (rst_sync)
    );

    pmrc_rst_qual #(
        .OSC_PER_MC  (OSC_PER_MC),
        .RST_QUAL_MC (RST_QUAL_MC)
    ) u_qual (
        .clk      (clk_osc),
        .arst_n   (por_n),
        .en       (qual_en),
        .rst_sync (rst_sync),
        .rst_ok   (rst_ok)
    );

    pmrc_osc_start #(.OSC_START_CNT(OSC_START_CNT)) u_start (
        .clk    (clk_osc),
        .arst_n (por_n),
        .en     (wake_en),
        .done   (start_done)
    );

    assign wake_en = (state == PM_WAKE);
    assign qual_en = (state != PM_WAKE) && (state != PM_PDOWN);

    // State register
    always_ff @(posedge clk_osc or negedge por_n) begin
        if (!por_n) state <= PM_WAKE;
        else        state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            PM_RUN: begin
                if (rst_ok)        state_nx = PM_RESET;
                else if (pd_req)   state_nx = PM_PDOWN;
                else if (idle_req) state_nx = PM_IDLE;
            end
            PM_IDLE: begin
                if (rst_ok)        state_nx = PM_RESET;
                else if (rst_sync) state_nx = PM_IDLE_EXIT;
                else if (irq_pend) state_nx = PM_RUN;
            end
            PM_IDLE_EXIT: begin
                if (rst_ok)         state_nx = PM_RESET;
                else if (!rst_sync) state_nx = PM_RUN;
            end
            PM_PDOWN: begin
                if (rst_sync) state_nx = PM_WAKE;
            end
            PM_WAKE: begin
                if (start_done) state_nx = PM_RESET;
            end
            PM_RESET: begin
                if (!rst_sync) state_nx = PM_RUN;
            end
            default: state_nx = PM_WAKE;
        endcase
    end

    // Output decode
    always_comb begin
        outs = '0;
        unique case (state)
            PM_RUN:       outs = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, rst: 1'b0, inh: 1'b0};
            PM_IDLE:      outs = '{cpu: 1'b0, per: 1'b1, osc: 1'b1, rst: 1'b0, inh: 1'b0};
            PM_IDLE_EXIT: outs = '{cpu: 1'b1, per: 1'b1, osc: 1'b1, rst: 1'b0, inh: 1'b1};
            PM_PDOWN:     outs = '{cpu: 1'b0, per: 1'b0, osc: 1'b0, rst: 1'b0, inh: 1'b0};
            PM_WAKE:      outs = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, rst: 1'b1, inh: 1'b1};
            PM_RESET:     outs = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, rst: 1'b1, inh: 1'b1};
            default:      outs = '{cpu: 1'b0, per: 1'b0, osc: 1'b1, rst: 1'b1, inh: 1'b1};
        endcase
    end

    assign cpu_clk_en = outs.cpu;
    assign per_clk_en = outs.per;
    assign osc_en     = outs.osc;
    assign sfr_rst    = outs.rst;
    assign ram_wr_inh = outs.inh;

    assert_clock_order_R10: assert property (@(posedge clk_osc) disable iff (!por_n)
        (cpu_clk_en |-> per_clk_en) and (per_clk_en |-> osc_en));

    assert_idle_entry_R2: assert property (@(posedge clk_osc) disable iff (!por_n)
        (state == PM_RUN) && idle_req && !pd_req && !rst_ok |=> !cpu_clk_en && per_clk_en);

    assert_pd_wins_R5: assert property (@(posedge clk_osc) disable iff (!por_n)
        (state == PM_RUN) && pd_req && !rst_ok |=> !osc_en);

    assert_pd_stays_R4: assert property (@(posedge clk_osc) disable iff (!por_n)
        (state == PM_PDOWN) && !rst_sync |=> !osc_en && !cpu_clk_en);

    assert_idle_window_R7: assert property (@(posedge clk_osc) disable iff (!por_n)
        (state == PM_IDLE) && rst_sync && !rst_ok |=> cpu_clk_en && ram_wr_inh);

    assert_wake_holds_R8: assert property (@(posedge clk_osc) disable iff (!por_n)
        $rose(osc_en) |=> !cpu_clk_en && sfr_rst);

    assert_rst_inhibits_R9: assert property (@(posedge clk_osc) disable iff (!por_n)
        sfr_rst |-> ram_wr_inh);

endmodule

// File: tb/pmrc_ctrl_tb.sv
module pmrc_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MC    = 12;
    localparam int QMC   = 2;
    localparam int START = 16;
    localparam int SYNC  = 2;
    localparam int QUAL  = MC * QMC;

    logic clk_osc = 1'b0;
    logic por_n = 1'b0;
    logic rst_pin = 1'b0;
    logic idle_req = 1'b0;
    logic pd_req = 1'b0;
    logic irq_pend = 1'b0;
    logic cpu_clk_en, per_clk_en, osc_en, sfr_rst, ram_wr_inh;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int order_bad = 0;

    always #(CLK_PERIOD/2) clk_osc = ~clk_osc;

    pmrc_ctrl #(
        .OSC_PER_MC(MC), .RST_QUAL_MC(QMC),
        .OSC_START_CNT(START), .SYNC_STAGES(SYNC)
    ) u_dut (
        .clk_osc(clk_osc), .por_n(por_n), .rst_pin(rst_pin),
        .idle_req(idle_req), .pd_req(pd_req), .irq_pend(irq_pend),
        .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
        .sfr_rst(sfr_rst), .ram_wr_inh(ram_wr_inh)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // R10 monitor on every sample
    always @(negedge clk_osc) begin
        cyc++;
        if (por_n && ((cpu_clk_en && !per_clk_en) || (per_clk_en && !osc_en)))
            order_bad++;
        if (cyc > 100000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=0", cyc);
            summary();
        end
    end

    task automatic pulse_strobe(input logic idl, input logic pd, input logic irq);
        idle_req = idl; pd_req = pd; irq_pend = irq;
        @(negedge clk_osc);
        idle_req = 0; pd_req = 0; irq_pend = 0;
    endtask

    initial begin
        int n;
        int seen;
        int win;
        int first;
        repeat (3) @(negedge clk_osc);
        // R1: power-on state
        chk("R1 sfr_rst", sfr_rst, 1);
        chk("R1 ram_wr_inh", ram_wr_inh, 1);
        chk("R1 osc_en", osc_en, 1);
        chk("R1 cpu_clk_en", cpu_clk_en, 0);
        chk("R1 per_clk_en", per_clk_en, 0);
        por_n = 1;
        n = 0;
        while (!cpu_clk_en && n < 200) begin @(negedge clk_osc); n++; end
        chk("R1 startup latency", n, START + 2);

        // R2: idle entry and repeated request
        pulse_strobe(1, 0, 0);
        chk("R2 cpu off", cpu_clk_en, 0);
        chk("R2 per on", per_clk_en, 1);
        chk("R2 osc on", osc_en, 1);
        pulse_strobe(1, 0, 0);
        repeat (3) @(negedge clk_osc);
        chk("R2 idle_req ignored", {cpu_clk_en, per_clk_en}, 1);

        // R3: interrupt ends idle
        pulse_strobe(0, 0, 1);
        chk("R3 cpu resumed", cpu_clk_en, 1);

        // R5 and R4: both requests, power-down wins
        pulse_strobe(1, 1, 0);
        chk("R5 osc off", osc_en, 0);
        chk("R4 per off", per_clk_en, 0);
        chk("R4 cpu off", cpu_clk_en, 0);
        irq_pend = 1;
        repeat (5) @(negedge clk_osc);
        irq_pend = 0;
        chk("R4 irq ignored", {osc_en, cpu_clk_en}, 0);
        pulse_strobe(1, 0, 0);
        @(negedge clk_osc);
        chk("R4 idle_req ignored", {osc_en, per_clk_en}, 0);

        // R8: wake from power-down
        rst_pin = 1;
        n = 0;
        while (!osc_en && n < 50) begin @(negedge clk_osc); n++; end
        chk("R8 osc restart latency", n, SYNC + 1);
        seen = 0;
        for (int i = 0; i < START + 40; i++) begin
            if (cpu_clk_en || !sfr_rst || !ram_wr_inh) seen++;
            @(negedge clk_osc);
        end
        chk("R8 R9 held in reset", seen, 0);
        rst_pin = 0;
        n = 0;
        while (!cpu_clk_en && n < 50) begin @(negedge clk_osc); n++; end
        chk("R9 release latency", n, SYNC + 1);

        // R6: pulse-width sweep in run
        for (int w = 1; w <= 30; w++) begin
            rst_pin = 1;
            repeat (w) @(negedge clk_osc);
            rst_pin = 0;
            seen = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk_osc);
                if (sfr_rst) begin
                    seen = 1;
                    chk("R9 inhibit with reset", ram_wr_inh, 1);
                end
            end
            chk($sformatf("R6 width %0d", w), seen, (w >= QUAL) ? 1 : 0);
        end

        // R6: qualification latency
        rst_pin = 1;
        n = 0;
        while (!sfr_rst && n < 100) begin @(negedge clk_osc); n++; end
        chk("R6 latency", n, SYNC + 1 + QUAL);
        rst_pin = 0;
        repeat (6) @(negedge clk_osc);
        chk("R9 back to run", cpu_clk_en, 1);

        // R7: reset ends idle with RAM-write window
        pulse_strobe(1, 0, 0);
        rst_pin = 1;
        n = 0; win = 0; first = -1;
        while (!sfr_rst && n < 100) begin
            @(negedge clk_osc); n++;
            if (cpu_clk_en && first < 0) first = n;
            if (cpu_clk_en && ram_wr_inh && !sfr_rst) win++;
        end
        chk("R7 cpu restart edge", first, SYNC + 1);
        chk("R7 window length", win, QUAL);
        rst_pin = 0;
        repeat (6) @(negedge clk_osc);

        // R7: short pulse in idle wakes without reset
        pulse_strobe(1, 0, 0);
        rst_pin = 1;
        repeat (5) @(negedge clk_osc);
        rst_pin = 0;
        seen = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk_osc);
            if (sfr_rst) seen = 1;
        end
        chk("R7 glitch no reset", seen, 0);
        chk("R7 glitch cpu on", cpu_clk_en, 1);
        chk("R7 glitch inhibit off", ram_wr_inh, 0);

        chk("R10 clock order", order_bad, 0);
        summary();
    end

endmodule